// File: doc/BRIEF.md
# Cache Injection Window Table

This block sits beside one processor's private cache in a bus-based shared-memory multiprocessor. Software running on that processor names, ahead of time, the address ranges of shared data it expects to consume, such as a lock word or a barrier structure. The block keeps these ranges and watches every snooped bus transaction. When a data-carrying transaction issued by another agent falls inside an open range, the block tells the cache controller to take that block into the local cache. The local processor never requested that block.

A range is built from two instruction operations. An open-low operation allocates an entry holding the first line. A later open-high operation gives the last line. A close operation names the low address and frees the entry. Two kinds of bus traffic feed the cache. One is a read reply sent to some other processor, so the first read serves every consumer. The other is an update pushed by a producer.

Top module: `inject_window_table`

## Requirements
- R1: After reset, `inject_valid` and `overflow` are 0 and the table is empty, so no snoop causes an injection.
- R2: After an open-low operation (`op_kind` = 1), a qualifying snoop to any byte of the same cache line raises `inject_valid` with `inject_addr` equal to the line-aligned address. Cache lines are `LINE_BYTES` (32) bytes.
- R3: After an open-high operation (`op_kind` = 2), the entry matches every line from its low line to its high line, both ends included. Lines just outside either end do not match.
- R4: Before its open-high arrives, an entry matches only its low line.
- R5: Open-high applies to the entry from the most recent open-low that has no high bound yet. It is ignored when no such entry exists, or when its line is below that entry's low line. An older entry that never received a high bound stays single-line.
- R6: A close operation (`op_kind` = 3) frees every entry whose low line equals the named line. A close that names no entry's low line has no effect. `op_kind` = 0 does nothing.
- R7: Only snoop kinds 1 (read reply to another requester) and 2 (update or store-update from a producer) can inject. Kinds 0 (request) and 3 (other) never inject.
- R8: A snoop marked as issued by the local processor (`snp_local` = 1) never injects.
- R9: When all `ENTRIES` (128) entries are in use, an open-low is dropped and sets `overflow`. `overflow` stays 1 until reset, and the existing entries keep matching.
- R10: `inject_valid` is registered and follows its snoop by one clock. An operation changes the table for snoops from the next cycle on. A snoop in the same cycle as the operation sees the old table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A window operation is present this cycle |
| op_kind | input | 2 | 0 none, 1 open-low, 2 open-high, 3 close |
| op_addr | input | ADDR_W | Byte address for the operation |
| snp_valid | input | 1 | A snooped bus transaction is present |
| snp_kind | input | 2 | 0 request, 1 read reply, 2 update, 3 other |
| snp_addr | input | ADDR_W | Byte address of the snooped block |
| snp_local | input | 1 | The transaction was issued by this processor |
| inject_valid | output | 1 | Capture the snooped block into the local cache |
| inject_addr | output | ADDR_W | Line-aligned address to capture |
| overflow | output | 1 | Sticky: an open-low was dropped because the table was full |

## Verification
A wrong bound, a lost valid bit or a misplaced pending pointer shows up as a missing or extra `inject_valid` on the clock after the first snoop that probes the affected line. The bench therefore probes each window at its low line, its high line and the lines just beyond them. A wrong free-entry search stays hidden until the table fills. It then shows as an early or late `overflow`, or as an older entry that stops matching. For that reason the full-table case is filled entry by entry, and the oldest windows are probed again afterwards.

// File: rtl/inject_window_table.sv
module inject_window_table #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int ENTRIES    = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_local,
  output logic              inject_valid,
  output logic [ADDR_W-1:0] inject_addr,
  output logic              overflow
);
  localparam int SH = $clog2(LINE_BYTES);
  localparam int LW = ADDR_W - SH;
  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld, hset;
  logic [LW-1:0]      lo [ENTRIES];
  logic [LW-1:0]      hi [ENTRIES];
  logic               pend_v;
  logic [IW-1:0]      pend_i;
  logic               free_ok, hit;
  logic [IW-1:0]      free_i;

  wire [LW-1:0] op_line  = op_addr[ADDR_W-1:SH];
  wire [LW-1:0] snp_line = snp_addr[ADDR_W-1:SH];
  wire snoop_ok = snp_valid && !snp_local && (snp_kind == 2'd1 || snp_kind == 2'd2);

  always_comb begin
    free_ok = 1'b0;
    free_i  = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (!vld[i]) begin
        free_ok = 1'b1;
        free_i  = IW'(i);
      end
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld[i] && (hset[i] ? (snp_line >= lo[i] && snp_line <= hi[i])
                             : (snp_line == lo[i])))
        hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld          <= '0;
      hset         <= '0;
      pend_v       <= 1'b0;
      pend_i       <= '0;
      overflow     <= 1'b0;
      inject_valid <= 1'b0;
      inject_addr  <= '0;
    end else begin
      inject_valid <= snoop_ok && hit;
      if (snoop_ok && hit) inject_addr <= {snp_line, {SH{1'b0}}};
      if (op_valid) begin
        case (op_kind)
          2'd1: begin
            if (free_ok) begin
              vld[free_i]  <= 1'b1;
              hset[free_i] <= 1'b0;
              lo[free_i]   <= op_line;
              pend_v       <= 1'b1;
              pend_i       <= free_i;
            end else begin
              overflow <= 1'b1;
            end
          end
          2'd2: begin
            if (pend_v && op_line >= lo[pend_i]) begin
              hi[pend_i]   <= op_line;
              hset[pend_i] <= 1'b1;
              pend_v       <= 1'b0;
            end
          end
          2'd3: begin
            for (int i = 0; i < ENTRIES; i++)
              if (vld[i] && lo[i] == op_line) begin
                vld[i] <= 1'b0;
                if (pend_v && pend_i == IW'(i)) pend_v <= 1'b0;
              end
          end
          default: ;
        endcase
      end
    end
  end

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && vld == '0) |=> !inject_valid); // R1
  AST_PEND_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> (vld[pend_i] && !hset[pend_i])); // R5
  AST_KIND_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && (snp_kind == 2'd0 || snp_kind == 2'd3)) |=> !inject_valid); // R7
  AST_LOCAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_local) |=> !inject_valid); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_INJ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inject_valid) |-> $past(snp_valid)); // R10
endmodule

// File: tb/tb_inject_window_table.sv
module tb_inject_window_table;
  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0, snp_valid = 0, snp_local = 0;
  logic [1:0]  op_kind = 0, snp_kind = 0;
  logic [31:0] op_addr = 0, snp_addr = 0;
  logic        inject_valid, overflow;
  logic [31:0] inject_addr;
  int checks = 0, fails = 0, cyc = 0;

  typedef struct { int due; logic v; logic [31:0] a; string tag; } item_t;
  item_t q[$];
  item_t it;

  inject_window_table dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (q.size() > 0 && q[0].due == cyc) begin
      it = q.pop_front();
      checks++;
      if (inject_valid !== it.v || (it.v && inject_addr !== it.a)) begin
        fails++;
        $display("FAIL %s: got v=%0b a=%h expected v=%0b a=%h",
                 it.tag, inject_valid, inject_addr, it.v, it.a);
      end
    end

  task automatic step(input logic ov, input logic [1:0] ok, input logic [31:0] oa,
                      input logic sv, input logic [1:0] sk, input logic [31:0] sa,
                      input logic sl, input logic ev, input logic [31:0] ea,
                      input string tag);
    item_t n;
    op_valid = ov; op_kind = ok; op_addr = oa;
    snp_valid = sv; snp_kind = sk; snp_addr = sa; snp_local = sl;
    n.due = cyc + 1; n.v = ev; n.a = ea; n.tag = tag;
    if (sv) q.push_back(n);
    @(negedge clk);
    op_valid = 0; snp_valid = 0; snp_local = 0;
  endtask

  task automatic op(input logic [1:0] k, input logic [31:0] a);
    step(1, k, a, 0, 0, 0, 0, 0, 0, "op");
  endtask

  task automatic snp(input logic [1:0] k, input logic [31:0] a, input logic l,
                     input logic ev, input logic [31:0] ea, input string tag);
    step(0, 0, 0, 1, k, a, l, ev, ea, tag);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(inject_valid, 0, "R1 inject after reset");
    chk(overflow, 0, "R1 overflow after reset");
    snp(1, 32'h1000, 0, 0, 0, "R1 empty table");

    op(1, 32'h1000);
    snp(1, 32'h1010, 0, 1, 32'h1000, "R2 low line hit");
    snp(1, 32'h1020, 0, 0, 0, "R4 next line before high");
    snp(2, 32'h1000, 0, 1, 32'h1000, "R7 update kind");
    snp(0, 32'h1000, 0, 0, 0, "R7 request kind");
    snp(3, 32'h1000, 0, 0, 0, "R7 other kind");
    snp(1, 32'h1000, 1, 0, 0, "R8 local origin");

    op(2, 32'h1060);
    snp(1, 32'h107F, 0, 1, 32'h1060, "R3 high line inclusive");
    snp(1, 32'h1040, 0, 1, 32'h1040, "R3 interior line");
    snp(1, 32'h1080, 0, 0, 0, "R3 above high");
    snp(1, 32'h0FE0, 0, 0, 0, "R3 below low");

    op(2, 32'h3000);
    snp(1, 32'h1080, 0, 0, 0, "R5 high without pending ignored");
    op(1, 32'h4000);
    op(1, 32'h5000);
    op(2, 32'h4FE0);
    snp(1, 32'h5000, 0, 1, 32'h5000, "R5 high below low ignored");
    snp(1, 32'h5020, 0, 0, 0, "R5 high below low keeps single line");
    op(2, 32'h5040);
    snp(1, 32'h5020, 0, 1, 32'h5020, "R5 high on latest low");
    snp(1, 32'h4020, 0, 0, 0, "R5 older entry single line");
    snp(1, 32'h4000, 0, 1, 32'h4000, "R5 older entry low line");

    step(1, 1, 32'h6000, 1, 1, 32'h6000, 0, 0, 0, "R10 same cycle sees old table");
    snp(1, 32'h6000, 0, 1, 32'h6000, "R10 next cycle sees new entry");

    op(3, 32'h7000);
    snp(1, 32'h1000, 0, 1, 32'h1000, "R6 unknown close ignored");
    op(0, 32'h1000);
    snp(1, 32'h1000, 0, 1, 32'h1000, "R6 kind 0 no effect");
    op(3, 32'h1000);
    snp(1, 32'h1020, 0, 0, 0, "R6 closed range");
    snp(1, 32'h1000, 0, 0, 0, "R6 closed low");

    for (int i = 0; i < 125; i++) op(1, 32'h0010_0000 + i * 32);
    chk(overflow, 0, "R9 no overflow at exactly full");
    snp(1, 32'h0010_0000 + 124 * 32, 0, 1, 32'h0010_0000 + 124 * 32, "R9 last entry fits");
    op(1, 32'h0090_0000);
    chk(overflow, 1, "R9 overflow set");
    snp(1, 32'h0090_0000, 0, 0, 0, "R9 dropped open");
    snp(1, 32'h5020, 0, 1, 32'h5020, "R9 old entries intact");
    op(3, 32'h4000);
    op(1, 32'h0091_0000);
    snp(1, 32'h0091_0000, 0, 1, 32'h0091_0000, "R9 freed entry reused");
    chk(overflow, 1, "R9 overflow sticky");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule